// File: doc/BRIEF.md
# Static Branch Predictor with Speculative Write-Back Gating

This block sits in the front end of an in-order dual-issue core and owns branch handling. Decoded branches arrive from the fetcher together with a static hint, the taken target and the fall-through address. Unconditional branches, and conditional branches whose condition is already known, are folded: the block picks the next fetch address on the spot and no execution slot or speculation is used.

A conditional branch whose condition still waits on in-flight work is predicted from its hint bit. Fetch continues down the predicted stream, and the branch becomes the single outstanding speculation. Non-branch instructions allocated while it is outstanding carry a speculative tag. They may execute, but their write-back enable stays low. A later branch is decoded but held until the outstanding one resolves.

On resolution a correct guess clears every tag, so the held write-backs proceed. A wrong guess raises a one-cycle flush, drops every tagged entry and redirects fetch to the correct path in the same cycle.

Top module: `bru_spec_ctrl`

## Requirements
- R1: A conditional branch with `br_cond_i`=1 and `br_cond_rdy_i`=0 that is accepted sets `fetch_pc_o` in that cycle to `br_target_i` when `br_hint_i`=1 and to `br_fallthru_i` when `br_hint_i`=0, and becomes the outstanding branch.
- R2: An unconditional branch (`br_cond_i`=0) that is accepted sets `fetch_pc_o` to `br_target_i` in the same cycle and leaves no outstanding branch, so a branch in the next cycle is not held.
- R3: A conditional branch with `br_cond_rdy_i`=1 is folded: `fetch_pc_o` is `br_target_i` when `br_cond_val_i`=1 and `br_fallthru_i` otherwise, in the same cycle, with no outstanding branch left and no write-back gating.
- R4: Entries allocated through `alloc_i` while a branch is outstanding, or in the cycle a branch becomes outstanding, get no `wb_en_o` bit until that branch resolves.
- R5: While a branch is outstanding, any branch presented on `br_valid_i` raises `hold_o` in that cycle, is not accepted, and `fetch_pc_o` equals `seq_pc_i`.
- R6: When `res_valid_i`=1 and `res_taken_i` equals the hint of the outstanding branch, `flush_o` stays low, `fetch_pc_o` equals `seq_pc_i`, and from the next cycle every live entry is non-speculative; entries allocated in the resolving cycle are non-speculative.
- R7: When `res_taken_i` differs from the outstanding hint, `flush_o` is high for exactly that cycle, `fetch_pc_o` in that cycle is the stored target if `res_taken_i`=1 and the stored fall-through otherwise, every speculative entry is gone from the next cycle, and allocations in the flush cycle are dropped.
- R8: After reset no branch is outstanding, no entry is live, `flush_o`, `hold_o` and `wb_en_o` are zero and `fetch_pc_o` follows `seq_pc_i`.
- R9: `wb_en_o[i]` is high exactly when entry i is live, not speculative and `exec_done_i[i]` is high; `retire_i[i]` frees entry i from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| br_valid_i | input | 1 | A decoded branch is presented |
| br_cond_i | input | 1 | 1: conditional branch, 0: unconditional |
| br_hint_i | input | 1 | Static hint, 1 predicts taken |
| br_cond_rdy_i | input | 1 | Condition already known, no dependence on in-flight work |
| br_cond_val_i | input | 1 | Known condition outcome, 1 = taken |
| br_target_i | input | PC_W | Taken target address |
| br_fallthru_i | input | PC_W | Fall-through address |
| seq_pc_i | input | PC_W | Sequential fetch address from the fetcher |
| res_valid_i | input | 1 | Outstanding branch resolves this cycle |
| res_taken_i | input | 1 | Actual outcome of the resolving branch |
| alloc_i | input | DEPTH | Entries allocated to issuing instructions (up to ISSUE_W bits) |
| exec_done_i | input | DEPTH | Entries that finished execution and want to write back |
| retire_i | input | DEPTH | Entries that completed write-back |
| fetch_pc_o | output | PC_W | Next fetch address |
| wb_en_o | output | DEPTH | Write-back enable per entry |
| flush_o | output | 1 | One-cycle flush of speculative entries |
| hold_o | output | 1 | Dispatch hold for a branch behind an outstanding one |

## Verification
A stale outstanding flag shows up at once as a wrongly raised or missing `hold_o` on the next branch and as `fetch_pc_o` ignoring the branch addresses. A wrong speculative tag is seen one cycle after allocation or resolution as a `wb_en_o` bit that is high too early or never comes back. A wrong stored hint or address appears in the resolving cycle itself as a missing or spurious `flush_o` or a wrong redirect address. The bench sweeps every combination of branch kind, hint, condition readiness, known value and actual outcome, so each of these paths is hit.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_FOLD = 2'd1,
    BR_SPEC = 2'd2,
    BR_HELD = 2'd3
  } br_class_e;
endpackage

// File: rtl/bru_classify.sv
module bru_classify
  import bru_pkg::*;
(
  input  logic      br_valid_i,
  input  logic      br_cond_i,
  input  logic      br_hint_i,
  input  logic      br_cond_rdy_i,
  input  logic      br_cond_val_i,
  input  logic      pend_i,
  output br_class_e cls_o,
  output logic      take_o
);
  always_comb begin
    cls_o  = BR_NONE;
    take_o = 1'b0;
    if (br_valid_i) begin
      if (pend_i) begin
        cls_o = BR_HELD;
      end else if (!br_cond_i || br_cond_rdy_i) begin
        cls_o  = BR_FOLD;
        take_o = !br_cond_i || br_cond_val_i;
      end else begin
        cls_o  = BR_SPEC;
        take_o = br_hint_i;
      end
    end
  end
endmodule

// File: rtl/bru_pend.sv
module bru_pend #(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            hint_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [PC_W-1:0] fallthru_i,
  input  logic            res_valid_i,
  input  logic            res_taken_i,
  output logic            pend_o,
  output logic            resolve_o,
  output logic            flush_o,
  output logic [PC_W-1:0] redirect_o
);
  logic            pend_q, pred_q;
  logic [PC_W-1:0] tgt_q, ft_q;

  assign pend_o     = pend_q;
  assign resolve_o  = pend_q && res_valid_i;
  assign flush_o    = resolve_o && (res_taken_i != pred_q);
  assign redirect_o = res_taken_i ? tgt_q : ft_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      pred_q <= 1'b0;
      tgt_q  <= '0;
      ft_q   <= '0;
    end else if (resolve_o) begin
      pend_q <= 1'b0;
    end else if (start_i) begin
      pend_q <= 1'b1;
      pred_q <= hint_i;
      tgt_q  <= target_i;
      ft_q   <= fallthru_i;
    end
  end

  // R7: flush is a single-cycle pulse
  a_r7_flush_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
  // R5: no second speculation while one is outstanding
  a_r5_no_start_while_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !start_i);
  // R1: a started branch is outstanding next cycle
  a_r1_start_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pend_q);
endmodule

// File: rtl/bru_spec_tbl.sv
module bru_spec_tbl #(
  parameter int DEPTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] alloc_i,
  input  logic             alloc_spec_i,
  input  logic             flush_i,
  input  logic             release_i,
  input  logic [DEPTH-1:0] retire_i,
  input  logic [DEPTH-1:0] done_i,
  output logic [DEPTH-1:0] wb_en_o,
  output logic [DEPTH-1:0] spec_o
);
  logic [DEPTH-1:0] live_q, spec_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q[i] <= 1'b0;
        spec_q[i] <= 1'b0;
      end else if (alloc_i[i] && !flush_i) begin
        live_q[i] <= 1'b1;
        spec_q[i] <= alloc_spec_i;
      end else if (retire_i[i] || (flush_i && spec_q[i])) begin
        live_q[i] <= 1'b0;
        spec_q[i] <= 1'b0;
      end else if (release_i) begin
        spec_q[i] <= 1'b0;
      end
    end
    assign wb_en_o[i] = live_q[i] && !spec_q[i] && done_i[i];
  end

  assign spec_o = spec_q;

  // R7: nothing speculative survives a flush
  a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (spec_q == '0));
  // R6: correct resolution leaves no speculative entry
  a_r6_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && !flush_i) |=> (spec_q == '0));
  // R4: a speculative entry is always live
  a_r4_spec_is_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((spec_q & ~live_q) == '0));
endmodule

// File: rtl/bru_spec_ctrl.sv
module bru_spec_ctrl
  import bru_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DEPTH   = 6,
  parameter int ISSUE_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             br_valid_i,
  input  logic             br_cond_i,
  input  logic             br_hint_i,
  input  logic             br_cond_rdy_i,
  input  logic             br_cond_val_i,
  input  logic [PC_W-1:0]  br_target_i,
  input  logic [PC_W-1:0]  br_fallthru_i,
  input  logic [PC_W-1:0]  seq_pc_i,
  input  logic             res_valid_i,
  input  logic             res_taken_i,
  input  logic [DEPTH-1:0] alloc_i,
  input  logic [DEPTH-1:0] exec_done_i,
  input  logic [DEPTH-1:0] retire_i,
  output logic [PC_W-1:0]  fetch_pc_o,
  output logic [DEPTH-1:0] wb_en_o,
  output logic             flush_o,
  output logic             hold_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  br_class_e       cls;
  logic            take, pend, resolve, flush, start, alloc_spec;
  logic [PC_W-1:0] redirect;
  logic [DEPTH-1:0] spec;

  bru_classify u_cls (
    .br_valid_i   (br_valid_i),
    .br_cond_i    (br_cond_i),
    .br_hint_i    (br_hint_i),
    .br_cond_rdy_i(br_cond_rdy_i),
    .br_cond_val_i(br_cond_val_i),
    .pend_i       (pend),
    .cls_o        (cls),
    .take_o       (take)
  );

  assign start = (cls == BR_SPEC);

  bru_pend #(.PC_W(PC_W)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .hint_i     (br_hint_i),
    .target_i   (br_target_i),
    .fallthru_i (br_fallthru_i),
    .res_valid_i(res_valid_i),
    .res_taken_i(res_taken_i),
    .pend_o     (pend),
    .resolve_o  (resolve),
    .flush_o    (flush),
    .redirect_o (redirect)
  );

  // younger issue in the same group as a new speculation is tagged too
  assign alloc_spec = (pend && !resolve) || start;

  bru_spec_tbl #(.DEPTH(DEPTH)) u_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc_i),
    .alloc_spec_i(alloc_spec),
    .flush_i     (flush),
    .release_i   (resolve),
    .retire_i    (retire_i),
    .done_i      (exec_done_i),
    .wb_en_o     (wb_en_o),
    .spec_o      (spec)
  );

  always_comb begin
    if (flush)
      fetch_pc_o = redirect;
    else if (cls == BR_FOLD || cls == BR_SPEC)
      fetch_pc_o = take ? br_target_i : br_fallthru_i;
    else
      fetch_pc_o = seq_pc_i;
  end

  assign flush_o = flush;
  assign hold_o  = (cls == BR_HELD);

  // R7: flush only in a resolving cycle
  a_r7_flush_needs_res: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> res_valid_i);
  // R5: a held branch never steers fetch
  a_r5_hold_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !flush_o) |-> (fetch_pc_o == seq_pc_i));
  // R4: no write-back while an entry is tagged
  a_r4_no_spec_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wb_en_o & spec) == '0));
  // R9: issue width respected on allocation
  a_r9_issue_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(alloc_i) <= ISSUE_W);
  // R2: spec tags exist only while a branch is outstanding or just resolved
  a_r2_tags_need_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec != '0) |-> pend);

  logic [CNT_W-1:0] unused_cnt;
  assign unused_cnt = CNT_W'(0);
endmodule

// File: tb/tb_bru_spec_ctrl.sv
module tb_bru_spec_ctrl;
  localparam int PC_W = 32, DEPTH = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic br_valid = 0, br_cond = 0, br_hint = 0, br_rdy = 0, br_val = 0;
  logic [PC_W-1:0] br_tgt = '0, br_ft = '0, seq_pc = 32'h0000_3000;
  logic res_valid = 0, res_taken = 0;
  logic [DEPTH-1:0] alloc = '0, done = '0, retire = '0;
  logic [PC_W-1:0] fetch_pc;
  logic [DEPTH-1:0] wb_en;
  logic flush, hold;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bru_spec_ctrl #(.PC_W(PC_W), .DEPTH(DEPTH), .ISSUE_W(2)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .br_valid_i(br_valid), .br_cond_i(br_cond), .br_hint_i(br_hint),
    .br_cond_rdy_i(br_rdy), .br_cond_val_i(br_val),
    .br_target_i(br_tgt), .br_fallthru_i(br_ft), .seq_pc_i(seq_pc),
    .res_valid_i(res_valid), .res_taken_i(res_taken),
    .alloc_i(alloc), .exec_done_i(done), .retire_i(retire),
    .fetch_pc_o(fetch_pc), .wb_en_o(wb_en), .flush_o(flush), .hold_o(hold)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    #1;
    chk(flush == 0, "R8 flush", 32'(flush), 0);
    chk(hold == 0, "R8 hold", 32'(hold), 0);
    chk(wb_en == 0, "R8 wb_en", 32'(wb_en), 0);
    chk(fetch_pc == seq_pc, "R8 fetch_pc", fetch_pc, seq_pc);
    step();
    rst_n = 1'b1;
    done = '1;
    step();
    #1;
    chk(wb_en == 0 && hold == 0, "R8 after release", 32'(wb_en), 0);

    for (int k = 0; k < 32; k++) begin
      bit c, h, r, v, a, spec, tk, mis;
      logic [PC_W-1:0] tgt, ft, probe;
      c = k[4]; h = k[3]; r = k[2]; v = k[1]; a = k[0];
      spec = c && !r;
      tk = spec ? h : (!c || v);
      tgt = 32'h0000_1000 + 32'(k) * 16;
      ft = 32'h0000_2000 + 32'(k) * 16;
      probe = 32'h0000_5000 + 32'(k) * 16;
      mis = spec && (a != h);

      step();
      br_valid = 1; br_cond = c; br_hint = h; br_rdy = r; br_val = v;
      br_tgt = tgt; br_ft = ft; alloc = 6'b000011;
      #1;
      chk(fetch_pc == (tk ? tgt : ft), spec ? "R1 predict pc" : (c ? "R3 fold pc" : "R2 fold pc"),
          fetch_pc, tk ? tgt : ft);
      chk(hold == 0 && flush == 0, "R1 no hold/flush", {30'd0, hold, flush}, 0);

      step();
      alloc = '0; br_cond = 0; br_tgt = probe; br_ft = probe + 4;
      #1;
      if (spec) begin
        chk(hold == 1, "R5 hold", 32'(hold), 1);
        chk(fetch_pc == seq_pc, "R5 fetch seq", fetch_pc, seq_pc);
        chk(wb_en == 0, "R4 gated", 32'(wb_en), 0);
      end else begin
        chk(hold == 0, c ? "R3 no pend" : "R2 no pend", 32'(hold), 0);
        chk(fetch_pc == probe, c ? "R3 next branch" : "R2 next branch", fetch_pc, probe);
        chk(wb_en == 6'b000011, c ? "R3 no gating" : "R2 no gating", 32'(wb_en), 32'h3);
      end

      step();
      br_valid = 0;
      if (spec) begin
        res_valid = 1; res_taken = a; alloc = 6'b000100;
        #1;
        chk(flush == mis, mis ? "R7 flush" : "R6 no flush", 32'(flush), 32'(mis));
        chk(fetch_pc == (mis ? (a ? tgt : ft) : seq_pc), mis ? "R7 redirect" : "R6 seq",
            fetch_pc, mis ? (a ? tgt : ft) : seq_pc);
        step();
        res_valid = 0; alloc = '0;
        #1;
        chk(flush == 0, "R7 single pulse", 32'(flush), 0);
        chk(wb_en == (mis ? 6'b000000 : 6'b000111), mis ? "R7 dropped" : "R6 released",
            32'(wb_en), mis ? 0 : 32'h7);
      end else begin
        done = 6'b000010;
        #1;
        chk(wb_en == 6'b000010, "R9 done mask", 32'(wb_en), 32'h2);
        done = '1;
      end

      step();
      retire = '1;
      step();
      retire = '0;
      #1;
      chk(wb_en == 0, "R9 retire frees", 32'(wb_en), 0);
      chk(hold == 0, "R9 idle", 32'(hold), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule